// File: doc/BRIEF.md
# Full-Map Directory Home Controller

This block is the home-side coherence engine for one memory region of a small cache-coherent NUMA machine. It keeps one directory entry per memory block. Each entry holds a home state (Uncached, Shared or Dirty) and a presence vector with one bit per node. The block also keeps the home copy of each block's data in a small internal array. Nodes send it read and write requests. It answers at once when the directory allows that. Otherwise it opens a single pending transaction: it multicasts invalidations to the other sharers, or asks the dirty owner to write the block back, and it grants the block once every acknowledgement or the write-back has arrived.

Three output channels are used, and each can carry one message per cycle. The reply channel answers the request just accepted. The command channel carries invalidations and write-back requests. The grant channel completes a pending transaction. When the forwarding input is high at request time, a write-back request tells the owner to send the block straight to the requester. The home still absorbs the write-back data, but it sends no grant of its own. The node caches are external, and in a test they are played by the bench.

Top module: `dir_fullmap_home`

## Requirements
- R1: After reset every entry is Uncached with an empty presence vector and zero home data, and no output channel is valid.
- R2: A read to an Uncached or Shared block returns a reply of kind 1 (data) on the next cycle, carrying the home data. The entry becomes Shared with the requester's bit added.
- R3: A write to a Shared block that has other sharers issues one command of kind 4 (invalidate). Its mask holds exactly the other sharers and never the requester. No grant is sent until an ack has arrived from every masked node. The cycle after the last ack, a grant of kind 2 (write ack) with the home data goes to the writer. Acks from unmasked nodes and repeated acks are ignored.
- R4: A write to an Uncached block, or a write from the only sharer of a Shared block, gets an immediate reply of kind 2 with the home data and no invalidations. The entry becomes Dirty with only the writer's bit set.
- R5: A read to a Dirty block issues a command of kind 5 (write-back request) whose mask is the owner alone and whose node field is the requester. On the owner's write-back the home stores the data, the entry becomes Shared with the owner and requester bits set, and a grant of kind 1 carries the written-back data to the requester.
- R6: A write to a Dirty block issues a kind 5 command in the same way. On write-back the home stores the data, the entry stays Dirty with only the requester's bit set, and a grant of kind 2 carries the data to the requester.
- R7: With forwarding high at request time, the kind 5 command has its forward flag set and no grant follows the write-back. Directory and home data are still updated as in R5 and R6.
- R8: A request to the block that owns the pending transaction gets a reply of kind 3 (retry) and changes nothing.
- R9: While a transaction is pending, a request to another block that would itself need to wait gets kind 3, while a request to another block that can be answered at once is served normally.
- R10: The outstanding-ack count is loaded with the popcount of the invalidation mask and always equals the number of masked nodes that have not yet acked.
- R11: A write-back from any node other than the recorded owner is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fwd_en | input | 1 | Owner forwards data directly for dirty misses |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_node | input | log2(NODES) | Requesting node |
| req_blk | input | log2(BLOCKS) | Requested block |
| ack_valid | input | 1 | Invalidation ack present |
| ack_node | input | log2(NODES) | Node sending the ack |
| wb_valid | input | 1 | Write-back data present |
| wb_node | input | log2(NODES) | Node sending the write-back |
| wb_data | input | DW | Written-back block data |
| rsp_valid | output | 1 | Immediate reply valid |
| rsp_kind | output | 3 | 1 data, 2 write ack, 3 retry |
| rsp_node | output | log2(NODES) | Reply destination |
| rsp_blk | output | log2(BLOCKS) | Reply block |
| rsp_data | output | DW | Reply data |
| cmd_valid | output | 1 | Coherence command valid |
| cmd_kind | output | 3 | 4 invalidate, 5 write-back request |
| cmd_mask | output | NODES | Destination nodes |
| cmd_node | output | log2(NODES) | Original requester |
| cmd_blk | output | log2(BLOCKS) | Command block |
| cmd_fwd | output | 1 | Owner sends data straight to requester |
| gnt_valid | output | 1 | Completion grant valid |
| gnt_kind | output | 3 | 1 data, 2 write ack |
| gnt_node | output | log2(NODES) | Grant destination |
| gnt_blk | output | log2(BLOCKS) | Grant block |
| gnt_data | output | DW | Grant data |

## Verification
Directed sequences come first. They build a three-way sharer set and then let a fourth node write. Its acks are fed with a stray node and a duplicate mixed in, which separates counting distinct masked acks from counting every ack pulse. While that invalidation is open, requests to the same block, to an Uncached block and to a Dirty block show apart the same-block retry, the immediate path and the busy-slot retry. A write-back from the wrong node tells owner matching apart from taking the first write-back that arrives. A long random stream then follows, with caches modelled in the bench and forwarding toggled at random. It covers every state transition under many sharer patterns, and later reads expose any home data that was lost on a write-back.

// File: rtl/dircc_pkg.sv
package dircc_pkg;
    localparam logic [2:0] K_DATA  = 3'd1;
    localparam logic [2:0] K_WACK  = 3'd2;
    localparam logic [2:0] K_RETRY = 3'd3;
    localparam logic [2:0] K_INV   = 3'd4;
    localparam logic [2:0] K_WBREQ = 3'd5;

    typedef enum logic [1:0] {
        HS_UNC = 2'd0,
        HS_SHR = 2'd1,
        HS_DTY = 2'd2
    } home_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_INV  = 2'd1,
        PH_WB   = 2'd2
    } phase_e;
endpackage

// File: rtl/dir_entry_store.sv
module dir_entry_store import dircc_pkg::*; #(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    parameter int DW     = 16,
    localparam int BW    = $clog2(BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BW-1:0]    rd_blk,
    output home_e            rd_st,
    output logic [NODES-1:0] rd_map,
    output logic [DW-1:0]    rd_data,
    input  logic [BW-1:0]    pb_blk,
    output logic [DW-1:0]    pb_data,
    input  logic             a_we,
    input  logic [BW-1:0]    a_blk,
    input  home_e            a_st,
    input  logic [NODES-1:0] a_map,
    input  logic             b_we,
    input  logic             b_dwe,
    input  logic [BW-1:0]    b_blk,
    input  home_e            b_st,
    input  logic [NODES-1:0] b_map,
    input  logic [DW-1:0]    b_data
);
    typedef struct packed {
        home_e            st;
        logic [NODES-1:0] map;
        logic [DW-1:0]    data;
    } entry_t;

    entry_t ent_q [BLOCKS];
    entry_t ent_d [BLOCKS];

    // Port A (request path) and port B (completion path) never address
    // the same block: requests to the pending block are refused.
    always_comb begin
        for (int i = 0; i < BLOCKS; i++) begin
            ent_d[i] = ent_q[i];
            if (a_we && a_blk == BW'(i)) begin
                ent_d[i].st  = a_st;
                ent_d[i].map = a_map;
            end
            if (b_we && b_blk == BW'(i)) begin
                ent_d[i].st  = b_st;
                ent_d[i].map = b_map;
                if (b_dwe) ent_d[i].data = b_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < BLOCKS; i++) begin
            if (!rst_n) ent_q[i] <= '0;
            else        ent_q[i] <= ent_d[i];
        end
    end

    assign rd_st   = ent_q[rd_blk].st;
    assign rd_map  = ent_q[rd_blk].map;
    assign rd_data = ent_q[rd_blk].data;
    assign pb_data = ent_q[pb_blk].data;
endmodule

// File: rtl/dir_ack_tracker.sv
module dir_ack_tracker #(
    parameter int NODES = 4,
    localparam int NW   = $clog2(NODES),
    localparam int CW   = $clog2(NODES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NODES-1:0] load_mask,
    input  logic             ack_valid,
    input  logic [NW-1:0]    ack_node,
    output logic [CW-1:0]    cnt,
    output logic [NODES-1:0] left,
    output logic             last
);
    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic [NODES-1:0] left;
    } trk_t;

    trk_t t_q, t_d;
    logic hit;
    logic [CW-1:0] pc;

    always_comb begin
        pc = '0;
        for (int i = 0; i < NODES; i++) pc = pc + CW'(load_mask[i]);
    end

    assign hit  = ack_valid && t_q.left[ack_node];
    assign last = hit && (t_q.cnt == CW'(1));

    always_comb begin
        t_d = t_q;
        if (load) begin
            t_d.cnt  = pc;
            t_d.left = load_mask;
        end else if (hit) begin
            t_d.cnt            = t_q.cnt - CW'(1);
            t_d.left[ack_node] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign cnt  = t_q.cnt;
    assign left = t_q.left;
endmodule

// File: rtl/dir_fullmap_home.sv
module dir_fullmap_home import dircc_pkg::*; #(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    parameter int DW     = 16,
    localparam int NW    = $clog2(NODES),
    localparam int BW    = $clog2(BLOCKS),
    localparam int CW    = $clog2(NODES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fwd_en,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [NW-1:0]    req_node,
    input  logic [BW-1:0]    req_blk,
    input  logic             ack_valid,
    input  logic [NW-1:0]    ack_node,
    input  logic             wb_valid,
    input  logic [NW-1:0]    wb_node,
    input  logic [DW-1:0]    wb_data,
    output logic             rsp_valid,
    output logic [2:0]       rsp_kind,
    output logic [NW-1:0]    rsp_node,
    output logic [BW-1:0]    rsp_blk,
    output logic [DW-1:0]    rsp_data,
    output logic             cmd_valid,
    output logic [2:0]       cmd_kind,
    output logic [NODES-1:0] cmd_mask,
    output logic [NW-1:0]    cmd_node,
    output logic [BW-1:0]    cmd_blk,
    output logic             cmd_fwd,
    output logic             gnt_valid,
    output logic [2:0]       gnt_kind,
    output logic [NW-1:0]    gnt_node,
    output logic [BW-1:0]    gnt_blk,
    output logic [DW-1:0]    gnt_data
);
    typedef struct packed {
        phase_e        ph;
        logic          wr;
        logic          fwd;
        logic [NW-1:0] node;
        logic [NW-1:0] owner;
        logic [BW-1:0] blk;
    } pend_t;

    typedef struct packed {
        logic             rsp_valid;
        logic [2:0]       rsp_kind;
        logic [NW-1:0]    rsp_node;
        logic [BW-1:0]    rsp_blk;
        logic [DW-1:0]    rsp_data;
        logic             cmd_valid;
        logic [2:0]       cmd_kind;
        logic [NODES-1:0] cmd_mask;
        logic [NW-1:0]    cmd_node;
        logic [BW-1:0]    cmd_blk;
        logic             cmd_fwd;
        logic             gnt_valid;
        logic [2:0]       gnt_kind;
        logic [NW-1:0]    gnt_node;
        logic [BW-1:0]    gnt_blk;
        logic [DW-1:0]    gnt_data;
    } out_t;

    typedef struct packed {
        pend_t p;
        out_t  o;
    } ctl_t;

    ctl_t s_q, s_d;

    // directory store wiring
    home_e            rd_st;
    logic [NODES-1:0] rd_map;
    logic [DW-1:0]    rd_data;
    logic [DW-1:0]    pb_data;
    logic             a_we, b_we, b_dwe;
    home_e            a_st, b_st;
    logic [NODES-1:0] a_map, b_map;
    logic [BW-1:0]    b_blk;
    logic [DW-1:0]    b_data;

    // ack tracker wiring
    logic             trk_load;
    logic [NODES-1:0] trk_lmask;
    logic [CW-1:0]    trk_cnt;
    logic [NODES-1:0] trk_left;
    logic             trk_last;

    // request-side helpers
    logic [NODES-1:0] req_bit, others;
    logic [NW-1:0]    owner_idx;
    logic             go_wb, go_inv, wb_hit;
    logic             busy_w;
    logic [BW-1:0]    pend_blk_w;

    dir_entry_store #(.NODES(NODES), .BLOCKS(BLOCKS), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_blk(req_blk), .rd_st(rd_st), .rd_map(rd_map), .rd_data(rd_data),
        .pb_blk(s_q.p.blk), .pb_data(pb_data),
        .a_we(a_we), .a_blk(req_blk), .a_st(a_st), .a_map(a_map),
        .b_we(b_we), .b_dwe(b_dwe), .b_blk(b_blk), .b_st(b_st),
        .b_map(b_map), .b_data(b_data)
    );

    dir_ack_tracker #(.NODES(NODES)) u_trk (
        .clk(clk), .rst_n(rst_n),
        .load(trk_load), .load_mask(trk_lmask),
        .ack_valid(ack_valid), .ack_node(ack_node),
        .cnt(trk_cnt), .left(trk_left), .last(trk_last)
    );

    assign busy_w     = (s_q.p.ph != PH_IDLE);
    assign pend_blk_w = s_q.p.blk;
    assign req_bit    = NODES'(1) << req_node;
    assign others     = rd_map & ~req_bit;
    assign wb_hit     = (s_q.p.ph == PH_WB) && wb_valid && (wb_node == s_q.p.owner);

    always_comb begin
        owner_idx = '0;
        for (int i = 0; i < NODES; i++)
            if (rd_map[i]) owner_idx = NW'(i);
    end

    always_comb begin
        s_d             = s_q;
        s_d.o.rsp_valid = 1'b0;
        s_d.o.cmd_valid = 1'b0;
        s_d.o.gnt_valid = 1'b0;
        a_we      = 1'b0;
        a_st      = HS_SHR;
        a_map     = rd_map | req_bit;
        b_we      = 1'b0;
        b_dwe     = 1'b0;
        b_blk     = s_q.p.blk;
        b_st      = HS_DTY;
        b_map     = NODES'(1) << s_q.p.node;
        b_data    = wb_data;
        trk_load  = 1'b0;
        trk_lmask = others;
        go_wb     = 1'b0;
        go_inv    = 1'b0;

        // ---------------- request path ----------------
        if (req_valid) begin
            s_d.o.rsp_node = req_node;
            s_d.o.rsp_blk  = req_blk;
            s_d.o.rsp_data = rd_data;
            s_d.o.rsp_kind = K_RETRY;
            if (busy_w && s_q.p.blk == req_blk) begin
                s_d.o.rsp_valid = 1'b1;
            end else if (!req_write) begin
                if (rd_st != HS_DTY) begin
                    s_d.o.rsp_valid = 1'b1;
                    s_d.o.rsp_kind  = K_DATA;
                    a_we            = 1'b1;
                    a_st            = HS_SHR;
                    a_map           = rd_map | req_bit;
                end else if (busy_w) begin
                    s_d.o.rsp_valid = 1'b1;
                end else begin
                    go_wb = 1'b1;
                end
            end else begin
                if (rd_st == HS_UNC || (rd_st == HS_SHR && others == '0)) begin
                    s_d.o.rsp_valid = 1'b1;
                    s_d.o.rsp_kind  = K_WACK;
                    a_we            = 1'b1;
                    a_st            = HS_DTY;
                    a_map           = req_bit;
                end else if (busy_w) begin
                    s_d.o.rsp_valid = 1'b1;
                end else if (rd_st == HS_SHR) begin
                    go_inv = 1'b1;
                end else begin
                    go_wb = 1'b1;
                end
            end
        end

        if (go_wb || go_inv) begin
            s_d.p.ph        = go_wb ? PH_WB : PH_INV;
            s_d.p.wr        = req_write;
            s_d.p.fwd       = go_wb && fwd_en;
            s_d.p.node      = req_node;
            s_d.p.owner     = owner_idx;
            s_d.p.blk       = req_blk;
            s_d.o.cmd_valid = 1'b1;
            s_d.o.cmd_kind  = go_wb ? K_WBREQ : K_INV;
            s_d.o.cmd_mask  = go_wb ? rd_map : others;
            s_d.o.cmd_node  = req_node;
            s_d.o.cmd_blk   = req_blk;
            s_d.o.cmd_fwd   = go_wb && fwd_en;
            trk_load        = go_inv;
        end

        // ---------------- completion path ----------------
        if (s_q.p.ph == PH_INV && trk_last) begin
            b_we            = 1'b1;
            b_st            = HS_DTY;
            b_map           = NODES'(1) << s_q.p.node;
            s_d.p.ph        = PH_IDLE;
            s_d.o.gnt_valid = 1'b1;
            s_d.o.gnt_kind  = K_WACK;
            s_d.o.gnt_node  = s_q.p.node;
            s_d.o.gnt_blk   = s_q.p.blk;
            s_d.o.gnt_data  = pb_data;
        end

        if (wb_hit) begin
            b_we   = 1'b1;
            b_dwe  = 1'b1;
            b_data = wb_data;
            if (s_q.p.wr) begin
                b_st  = HS_DTY;
                b_map = NODES'(1) << s_q.p.node;
            end else begin
                b_st  = HS_SHR;
                b_map = (NODES'(1) << s_q.p.node) | (NODES'(1) << s_q.p.owner);
            end
            s_d.p.ph        = PH_IDLE;
            s_d.o.gnt_valid = !s_q.p.fwd;
            s_d.o.gnt_kind  = s_q.p.wr ? K_WACK : K_DATA;
            s_d.o.gnt_node  = s_q.p.node;
            s_d.o.gnt_blk   = s_q.p.blk;
            s_d.o.gnt_data  = wb_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid = s_q.o.rsp_valid;
    assign rsp_kind  = s_q.o.rsp_kind;
    assign rsp_node  = s_q.o.rsp_node;
    assign rsp_blk   = s_q.o.rsp_blk;
    assign rsp_data  = s_q.o.rsp_data;
    assign cmd_valid = s_q.o.cmd_valid;
    assign cmd_kind  = s_q.o.cmd_kind;
    assign cmd_mask  = s_q.o.cmd_mask;
    assign cmd_node  = s_q.o.cmd_node;
    assign cmd_blk   = s_q.o.cmd_blk;
    assign cmd_fwd   = s_q.o.cmd_fwd;
    assign gnt_valid = s_q.o.gnt_valid;
    assign gnt_kind  = s_q.o.gnt_kind;
    assign gnt_node  = s_q.o.gnt_node;
    assign gnt_blk   = s_q.o.gnt_blk;
    assign gnt_data  = s_q.o.gnt_data;
endmodule

// File: rtl/dir_fullmap_chk.sv
module dir_fullmap_chk #(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    localparam int NW    = $clog2(NODES),
    localparam int BW    = $clog2(BLOCKS),
    localparam int CW    = $clog2(NODES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [BW-1:0]    req_blk,
    input logic             rsp_valid,
    input logic [2:0]       rsp_kind,
    input logic             cmd_valid,
    input logic [2:0]       cmd_kind,
    input logic [NODES-1:0] cmd_mask,
    input logic [NW-1:0]    cmd_node,
    input logic             gnt_valid,
    input logic [2:0]       gnt_kind,
    input logic             busy,
    input logic [BW-1:0]    pend_blk,
    input logic [CW-1:0]    trk_cnt,
    input logic [NODES-1:0] trk_left,
    input logic             trk_last
);
    // R2/R9: each accepted request is answered on exactly one channel
    p_one_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_valid != cmd_valid));

    p_retry_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy && req_blk == pend_blk) |=> (rsp_valid && rsp_kind == 3'd3));

    p_inv_excludes_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 3'd4) |-> (!cmd_mask[cmd_node] && cmd_mask != '0));

    p_grant_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trk_last |=> (gnt_valid && gnt_kind == 3'd2));

    p_cnt_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 3'd4) |-> (trk_cnt == CW'($countones(cmd_mask))));

    p_cnt_tracks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trk_cnt == CW'($countones(trk_left)));

    p_wbreq_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 3'd5) |-> ($countones(cmd_mask) == 1));

    p_grant_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> $past(busy));
endmodule

bind dir_fullmap_home dir_fullmap_chk #(.NODES(NODES), .BLOCKS(BLOCKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_blk(req_blk),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_mask(cmd_mask), .cmd_node(cmd_node),
    .gnt_valid(gnt_valid), .gnt_kind(gnt_kind),
    .busy(busy_w), .pend_blk(pend_blk_w),
    .trk_cnt(trk_cnt), .trk_left(trk_left), .trk_last(trk_last)
);

// File: tb/sim_dir_fullmap_home.sv
module sim_dir_fullmap_home;
    localparam int CLK_PERIOD = 10;
    localparam int NODES  = 4;
    localparam int BLOCKS = 8;
    localparam int DW     = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fwd_en = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_node = '0;
    logic [2:0] req_blk = '0;
    logic ack_valid = 1'b0;
    logic [1:0] ack_node = '0;
    logic wb_valid = 1'b0;
    logic [1:0] wb_node = '0;
    logic [15:0] wb_data = '0;
    logic rsp_valid, cmd_valid, gnt_valid, cmd_fwd;
    logic [2:0] rsp_kind, cmd_kind, gnt_kind;
    logic [1:0] rsp_node, cmd_node, gnt_node;
    logic [2:0] rsp_blk, cmd_blk, gnt_blk;
    logic [15:0] rsp_data, gnt_data;
    logic [3:0] cmd_mask;

    int n_chk = 0;
    int n_err = 0;

    // bench model of the directory
    int         m_st   [BLOCKS];
    logic [3:0] m_map  [BLOCKS];
    logic [15:0] m_data [BLOCKS];

    always #(CLK_PERIOD/2) clk = ~clk;

    dir_fullmap_home #(.NODES(NODES), .BLOCKS(BLOCKS), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en),
        .req_valid(req_valid), .req_write(req_write), .req_node(req_node), .req_blk(req_blk),
        .ack_valid(ack_valid), .ack_node(ack_node),
        .wb_valid(wb_valid), .wb_node(wb_node), .wb_data(wb_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_node(rsp_node), .rsp_blk(rsp_blk),
        .rsp_data(rsp_data),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_mask(cmd_mask), .cmd_node(cmd_node),
        .cmd_blk(cmd_blk), .cmd_fwd(cmd_fwd),
        .gnt_valid(gnt_valid), .gnt_kind(gnt_kind), .gnt_node(gnt_node), .gnt_blk(gnt_blk),
        .gnt_data(gnt_data)
    );

    task automatic check(input string rq, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // drive one request for one cycle; returns at the negedge where outputs show the reply
    task automatic send_req(input int node, input int blk, input bit wr, input bit fwd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_node = 2'(node); req_blk = 3'(blk); fwd_en = fwd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_ack(input int node);
        @(negedge clk);
        ack_valid = 1'b1; ack_node = 2'(node);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic send_wb(input int node, input logic [15:0] d);
        @(negedge clk);
        wb_valid = 1'b1; wb_node = 2'(node); wb_data = d;
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    function automatic int owner_of(input logic [3:0] m);
        int o = 0;
        for (int i = 0; i < NODES; i++) if (m[i]) o = i;
        return o;
    endfunction

    // full transaction against the model
    task automatic txn(input int node, input int blk, input bit wr, input bit fwd);
        int st;
        logic [3:0] map, bitv, others;
        st = m_st[blk]; map = m_map[blk];
        bitv = 4'(1) << node; others = map & ~bitv;
        send_req(node, blk, wr, fwd);
        if (!wr && st != 2) begin
            check("R2", "read rsp", {rsp_valid, cmd_valid, rsp_kind}, {2'b10, 3'd1});
            check("R2", "read data", rsp_data, m_data[blk]);
            check("R2", "read dst", {rsp_node, rsp_blk}, {2'(node), 3'(blk)});
            m_st[blk] = 1; m_map[blk] = map | bitv;
        end else if (wr && (st == 0 || (st == 1 && others == 0))) begin
            check("R4", "imm wack", {rsp_valid, cmd_valid, rsp_kind}, {2'b10, 3'd2});
            check("R4", "imm data", rsp_data, m_data[blk]);
            m_st[blk] = 2; m_map[blk] = bitv;
        end else if (wr && st == 1) begin
            int ord [4];
            int n = 0;
            check("R3", "inv cmd", {rsp_valid, cmd_valid, cmd_kind}, {2'b01, 3'd4});
            check("R3", "inv mask", cmd_mask, others);
            for (int i = 0; i < NODES; i++) if (others[i]) begin ord[n] = i; n++; end
            for (int i = n - 1; i > 0; i--) begin
                int j = int'($urandom % (i + 1));
                int t = ord[i]; ord[i] = ord[j]; ord[j] = t;
            end
            for (int k = 0; k < n; k++) begin
                repeat ($urandom % 3) @(negedge clk);
                send_ack(ord[k]);
                if (k < n - 1) check("R3", "early grant", gnt_valid, 0);
                else begin
                    check("R3", "grant", {gnt_valid, gnt_kind}, {1'b1, 3'd2});
                    check("R3", "grant dst", {gnt_node, gnt_blk}, {2'(node), 3'(blk)});
                    check("R3", "grant data", gnt_data, m_data[blk]);
                end
            end
            m_st[blk] = 2; m_map[blk] = bitv;
        end else begin
            logic [15:0] nd;
            int own = owner_of(map);
            nd = 16'($urandom);
            check(wr ? "R6" : "R5", "wbreq", {rsp_valid, cmd_valid, cmd_kind}, {2'b01, 3'd5});
            check(wr ? "R6" : "R5", "wbreq mask/node", {cmd_mask, cmd_node}, {map, 2'(node)});
            check("R7", "fwd flag", cmd_fwd, fwd);
            send_wb(own, nd);
            if (fwd) check("R7", "no grant fwd", gnt_valid, 0);
            else begin
                check(wr ? "R6" : "R5", "grant", {gnt_valid, gnt_kind}, {1'b1, wr ? 3'd2 : 3'd1});
                check(wr ? "R6" : "R5", "grant data", gnt_data, nd);
                check(wr ? "R6" : "R5", "grant node", gnt_node, node);
            end
            m_data[blk] = nd;
            if (wr) begin m_st[blk] = 2; m_map[blk] = bitv; end
            else    begin m_st[blk] = 1; m_map[blk] = map | bitv; end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd41));
        for (int b = 0; b < BLOCKS; b++) begin m_st[b] = 0; m_map[b] = '0; m_data[b] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle outputs", {rsp_valid, cmd_valid, gnt_valid}, 0);

        // reset data is zero; sharers build up
        txn(0, 1, 0, 0);
        check("R1", "reset data", rsp_data, 0);
        txn(1, 1, 0, 0);
        txn(2, 1, 0, 0);
        txn(2, 5, 1, 0);                 // Uncached write: immediate (R4)

        // open an invalidation on blk1 and probe while it is pending
        send_req(3, 1, 1, 0);
        check("R3", "inv mask 3-way", {cmd_valid, cmd_kind, cmd_mask}, {1'b1, 3'd4, 4'b0111});
        send_req(0, 1, 0, 0);
        check("R8", "same blk retry", {rsp_valid, rsp_kind}, {1'b1, 3'd3});
        send_req(3, 2, 0, 0);
        check("R9", "other blk served", {rsp_valid, rsp_kind, rsp_data}, {1'b1, 3'd1, 16'd0});
        m_st[2] = 1; m_map[2] = 4'b1000;
        send_req(1, 5, 1, 0);
        check("R9", "busy slot retry", {rsp_valid, rsp_kind, cmd_valid}, {1'b1, 3'd3, 1'b0});
        send_ack(3);
        check("R3", "stray ack ignored", gnt_valid, 0);
        send_ack(0);
        send_ack(0);
        check("R3", "dup ack ignored", gnt_valid, 0);
        send_ack(1);
        check("R3", "grant before last", gnt_valid, 0);
        send_ack(2);
        check("R3", "grant after last", {gnt_valid, gnt_kind, gnt_node}, {1'b1, 3'd2, 2'd3});
        m_st[1] = 2; m_map[1] = 4'b1000;
        send_req(0, 1, 0, 0);
        check("R8", "retry left state alone", {cmd_valid, cmd_mask}, {1'b1, 4'b1000});
        send_wb(3, 16'h1234);
        check("R5", "grant after wb", {gnt_valid, gnt_kind, gnt_data}, {1'b1, 3'd1, 16'h1234});
        m_st[1] = 1; m_map[1] = 4'b1001; m_data[1] = 16'h1234;

        // sole sharer upgrade (R4)
        txn(3, 3, 0, 0);
        send_req(3, 3, 1, 0);
        check("R4", "sole sharer wack", {rsp_valid, rsp_kind, cmd_valid}, {1'b1, 3'd2, 1'b0});
        m_st[3] = 2; m_map[3] = 4'b1000;

        // wrong-node write-back ignored (R11)
        send_req(0, 5, 0, 0);
        check("R5", "wbreq owner", {cmd_valid, cmd_kind, cmd_mask}, {1'b1, 3'd5, 4'b0100});
        send_wb(1, 16'hdead);
        check("R11", "wrong wb ignored", gnt_valid, 0);
        send_wb(2, 16'h00aa);
        check("R11", "owner wb taken", {gnt_valid, gnt_data}, {1'b1, 16'h00aa});
        m_st[5] = 1; m_map[5] = 4'b0101; m_data[5] = 16'h00aa;
        txn(1, 5, 0, 0);
        check("R5", "stored wb data", rsp_data, 16'h00aa);

        // forwarding write to dirty, then read stored value (R7)
        txn(0, 3, 1, 1);
        txn(1, 3, 0, 0);

        // random stream with a bench cache model
        for (int it = 0; it < 600; it++) begin
            int node = int'($urandom % NODES);
            int blk  = int'($urandom % BLOCKS);
            bit wr   = 1'($urandom % 2);
            bit fwd  = 1'($urandom % 2);
            if (!wr && m_map[blk][node]) continue;
            if (wr && m_st[blk] == 2 && m_map[blk][node]) continue;
            txn(node, blk, wr, fwd);
        end

        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule